// File: doc/BRIEF.md
# Indexed Control Register Port with Interrupt Status

This block puts a 128-byte register space behind two host addresses. A write to the even address selects which byte is reached. A read or write at the odd address then reads or writes the selected byte. Most bytes are plain storage. Four of them are control and status registers (A, B, C and D), and each of these follows its own access rules.

Neighbouring timekeeping blocks send one-cycle pulses that set flags in status register C: a periodic flag, an alarm flag and an update-ended flag. They also report the update-in-progress condition, which appears as a read-only bit of register A. Register B holds the interrupt enables. The interrupt line is a small two-state machine.

- `IRQ_IDLE` moves to `IRQ_ASSERTED` in two cases: an enabled flag arrives, or a register-B write enables a flag that is already set.
- `IRQ_ASSERTED` returns to `IRQ_IDLE` in two cases: a read of register C, unless an enabled flag arrives in that same cycle, or a register-B write that enables no set flag.

Registers A and B are also driven out continuously, so that the rate and time-of-day logic can use them.

Top module: `cmos_regport`

## Requirements
- R1: A host write with `bus_addr`=0 loads bits 6:0 of the write data as the index; bit 7 is discarded. A host read with `bus_addr`=0 returns 0xFF.
- R2: At `bus_addr`=1, a write to any index other than 0x0A–0x0D stores the byte, and a later read of that index returns it.
- R3: Writes to index 0x0C (register C) and index 0x0D (register D) are ignored. Register D always reads 0x80, where bit 7 marks RAM and time as valid.
- R4: A read of register C returns its current contents. At the same clock edge it clears every flag and IRQF and drops `irq`.
- R5: A pulse on `pf_set`, `af_set` or `uf_set` sets C bit 6, bit 5 or bit 4 respectively. If the matching enable in register B is high (bit 6, bit 5 or bit 4), C bit 7 (IRQF) is also set and `irq` rises one cycle later.
- R6: A write to register B (index 0x0B) sets IRQF and raises `irq` when any of data bits 6:4 meets a set flag in C. Otherwise the write clears IRQF and lowers `irq`. The flag bits are kept in both cases.
- R7: Register A bit 7 (update in progress) is read-only and follows `uip_in`, registered once. A write to register A (index 0x0A) changes only bits 6:0.
- R8: After reset, A reads 0x26, B reads 0x02, C reads 0x00 and D reads 0x80, and `irq` is low. The reset value of B therefore has the periodic, alarm and square-wave enables (bits 6, 5, 3) cleared.
- R9: A flag pulse that coincides with a read of register C is not returned by that read. It is kept, and the next read returns it, with IRQF set if the flag is enabled.
- R10: `irq` always equals C bit 7 as seen by a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_addr | input | 1 | 0 selects the index, 1 selects the indexed byte |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, valid in the cycle of `bus_rd` |
| pf_set | input | 1 | Periodic flag set pulse |
| af_set | input | 1 | Alarm flag set pulse |
| uf_set | input | 1 | Update-ended flag set pulse |
| uip_in | input | 1 | Update-in-progress status from the time-of-day logic |
| irq | output | 1 | Interrupt request, high while IRQF is set |
| ctrl_a | output | 8 | Current register A |
| ctrl_b | output | 8 | Current register B |

## Verification
Every fault in the interrupt state machine or the flag register shows up at `irq` within one clock. It also shows up in the byte returned by the next register-C read. Wrong indexing or wrong protection of registers C and D appears on the very next odd-address read, either as a stored byte that was lost or as a read-only value that changed. The most delicate case is a flag pulse landing in the same cycle as the clearing read. If that pulse is dropped, `irq` stays low and the following read returns zero.

// File: rtl/cmos_pkg.sv
package cmos_pkg;
    localparam int IDX_W     = 7;
    localparam int DATA_W    = 8;
    localparam int SPACE     = 1 << IDX_W;
    localparam int NFLAG     = 3;

    localparam logic [IDX_W-1:0] IDX_A = 7'h0A;
    localparam logic [IDX_W-1:0] IDX_B = 7'h0B;
    localparam logic [IDX_W-1:0] IDX_C = 7'h0C;
    localparam logic [IDX_W-1:0] IDX_D = 7'h0D;

    localparam logic [DATA_W-1:0] RST_A   = 8'h26;
    localparam logic [DATA_W-1:0] RST_B   = 8'h02;
    localparam logic [DATA_W-1:0] CONST_D = 8'h80;
    localparam logic [DATA_W-1:0] IDLE_RD = 8'hFF;

    // flags and enables occupy bits 6:4 in both C and B, ordered {periodic, alarm, update}
    localparam int FLAG_LO = 4;
    localparam int FLAG_HI = FLAG_LO + NFLAG - 1;
    localparam int IRQF_BIT = 7;
    localparam int UIP_BIT  = 7;

    typedef enum logic [0:0] {
        IRQ_IDLE     = 1'b0,
        IRQ_ASSERTED = 1'b1
    } irq_state_t;
endpackage

// File: rtl/cmos_store.sv
module cmos_store #(
    parameter int DEPTH  = 128,
    parameter int WIDTH  = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/cmos_ctrl_regs.sv
module cmos_ctrl_regs
    import cmos_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic [DATA_W-1:0] wdata,
    input  logic              uip_in,
    output logic [DATA_W-1:0] reg_a,
    output logic [DATA_W-1:0] reg_b
);
    logic              uip_q;
    logic [UIP_BIT-1:0] a_low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uip_q   <= RST_A[UIP_BIT];
            a_low_q <= RST_A[UIP_BIT-1:0];
            reg_b   <= RST_B;
        end else begin
            uip_q <= uip_in;
            if (wr_a) begin
                a_low_q <= wdata[UIP_BIT-1:0];
            end
            if (wr_b) begin
                reg_b <= wdata;
            end
        end
    end

    assign reg_a = {uip_q, a_low_q};
endmodule

// File: rtl/cmos_intr_ctl.sv
module cmos_intr_ctl
    import cmos_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] flag_set,
    input  logic [NFLAG-1:0] enables,
    input  logic             rd_clr,
    input  logic             b_wr,
    input  logic [NFLAG-1:0] b_new_en,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);
    irq_state_t      state_q, state_d;
    logic [NFLAG-1:0] flags_d;
    logic            hit_now;
    logic            hit_bwr;

    always_comb begin
        flags_d = (rd_clr ? '0 : flags) | flag_set;
        hit_now = |(flag_set & enables);
        hit_bwr = |(flags_d & b_new_en);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (b_wr) begin
                    state_d = hit_bwr ? IRQ_ASSERTED : IRQ_IDLE;
                end else if (hit_now) begin
                    state_d = IRQ_ASSERTED;
                end
            end
            IRQ_ASSERTED: begin
                if (b_wr) begin
                    state_d = hit_bwr ? IRQ_ASSERTED : IRQ_IDLE;
                end else if (rd_clr) begin
                    state_d = hit_now ? IRQ_ASSERTED : IRQ_IDLE;
                end
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
            flags   <= '0;
        end else begin
            state_q <= state_d;
            flags   <= flags_d;
        end
    end

    always_comb begin
        irq = (state_q == IRQ_ASSERTED);
    end
endmodule

// File: rtl/cmos_regport.sv
module cmos_regport
    import cmos_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pf_set,
    input  logic              af_set,
    input  logic              uf_set,
    input  logic              uip_in,
    output logic              irq,
    output logic [DATA_W-1:0] ctrl_a,
    output logic [DATA_W-1:0] ctrl_b
);
    logic [IDX_W-1:0]  index_q;
    logic [DATA_W-1:0] store_rd;
    logic [NFLAG-1:0]  flags;
    logic [DATA_W-1:0] c_val;
    logic              data_wr, data_rd;
    logic              is_ctrl;
    logic              wr_a, wr_b, wr_store, rd_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index_q <= '0;
        end else if (bus_wr && !bus_addr) begin
            index_q <= bus_wdata[IDX_W-1:0];
        end
    end

    always_comb begin
        data_wr  = bus_wr && bus_addr;
        data_rd  = bus_rd && bus_addr;
        is_ctrl  = (index_q >= IDX_A) && (index_q <= IDX_D);
        wr_a     = data_wr && (index_q == IDX_A);
        wr_b     = data_wr && (index_q == IDX_B);
        wr_store = data_wr && !is_ctrl;
        rd_c     = data_rd && (index_q == IDX_C);
    end

    cmos_store #(
        .DEPTH (SPACE),
        .WIDTH (DATA_W)
    ) u_store (
        .clk   (clk),
        .we    (wr_store),
        .addr  (index_q),
        .wdata (bus_wdata),
        .rdata (store_rd)
    );

    cmos_ctrl_regs u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_a   (wr_a),
        .wr_b   (wr_b),
        .wdata  (bus_wdata),
        .uip_in (uip_in),
        .reg_a  (ctrl_a),
        .reg_b  (ctrl_b)
    );

    cmos_intr_ctl u_intr (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_set ({pf_set, af_set, uf_set}),
        .enables  (ctrl_b[FLAG_HI:FLAG_LO]),
        .rd_clr   (rd_c),
        .b_wr     (wr_b),
        .b_new_en (bus_wdata[FLAG_HI:FLAG_LO]),
        .flags    (flags),
        .irq      (irq)
    );

    always_comb begin
        c_val = '0;
        c_val[IRQF_BIT] = irq;
        c_val[FLAG_HI:FLAG_LO] = flags;
    end

    always_comb begin
        if (!bus_addr) begin
            bus_rdata = IDLE_RD;
        end else begin
            unique case (index_q)
                IDX_A:   bus_rdata = ctrl_a;
                IDX_B:   bus_rdata = ctrl_b;
                IDX_C:   bus_rdata = c_val;
                IDX_D:   bus_rdata = CONST_D;
                default: bus_rdata = store_rd;
            endcase
        end
    end
endmodule

// File: rtl/cmos_regport_chk.sv
module cmos_regport_chk
    import cmos_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              pf_set,
    input logic              af_set,
    input logic              uf_set,
    input logic              uip_in,
    input logic              irq,
    input logic [DATA_W-1:0] ctrl_a,
    input logic [DATA_W-1:0] ctrl_b,
    input logic [IDX_W-1:0]  index_q,
    input logic [DATA_W-1:0] c_val
);
    logic any_set;
    assign any_set = pf_set | af_set | uf_set;

    a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr) |=> (index_q == $past(bus_wdata[IDX_W-1:0])));

    a_r3_c_unwritable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && index_q == IDX_C && !any_set && !bus_rd) |=> $stable(c_val));

    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr && index_q == IDX_C && !any_set) |=> (!irq && c_val == '0));

    a_r5_enabled_flag_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_set && ctrl_b[FLAG_HI] && !(bus_wr && bus_addr && index_q == IDX_B)) |=> irq);

    a_r6_bwrite_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && index_q == IDX_B && bus_wdata[FLAG_HI:FLAG_LO] == '0) |=> !irq);

    a_r7_uip_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ctrl_a[UIP_BIT] == $past(uip_in)));
endmodule

bind cmos_regport cmos_regport_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pf_set    (pf_set),
    .af_set    (af_set),
    .uf_set    (uf_set),
    .uip_in    (uip_in),
    .irq       (irq),
    .ctrl_a    (ctrl_a),
    .ctrl_b    (ctrl_b),
    .index_q   (index_q),
    .c_val     (c_val)
);

// File: tb/sim_cmos_regport.sv
`timescale 1ns/1ps
module sim_cmos_regport;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       pf_set = 1'b0, af_set = 1'b0, uf_set = 1'b0, uip_in = 1'b0;
    logic       irq;
    logic [7:0] ctrl_a, ctrl_b;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cmos_regport u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pf_set(pf_set), .af_set(af_set), .uf_set(uf_set), .uip_in(uip_in),
        .irq(irq), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic reg_read(input logic [6:0] idx, output logic [7:0] d);
        bus_write(1'b0, {1'b0, idx});
        bus_read(1'b1, d);
    endtask

    task automatic reg_write(input logic [6:0] idx, input logic [7:0] d);
        bus_write(1'b0, {1'b0, idx});
        bus_write(1'b1, d);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) pf_set = 1'b1;
        if (which == 1) af_set = 1'b1;
        if (which == 2) uf_set = 1'b1;
        @(negedge clk);
        pf_set = 1'b0; af_set = 1'b0; uf_set = 1'b0;
    endtask

    task automatic t_reset_values();
        logic [7:0] v;
        check("R8 irq after reset", {7'h0, irq}, 8'h00);
        reg_read(7'h0A, v); check("R8 reg A", v, 8'h26);
        reg_read(7'h0B, v); check("R8 reg B", v, 8'h02);
        reg_read(7'h0C, v); check("R8 reg C", v, 8'h00);
        reg_read(7'h0D, v); check("R8 reg D", v, 8'h80);
    endtask

    task automatic t_index_and_store();
        logic [7:0] v;
        bus_read(1'b0, v); check("R1 even read", v, 8'hFF);
        bus_write(1'b0, 8'h85);
        bus_write(1'b1, 8'h5A);
        reg_read(7'h05, v); check("R1 index bit7 dropped", v, 8'h5A);
        reg_write(7'h40, 8'hC3);
        reg_write(7'h7F, 8'h11);
        reg_read(7'h40, v); check("R2 store 0x40", v, 8'hC3);
        reg_read(7'h7F, v); check("R2 store 0x7F", v, 8'h11);
    endtask

    task automatic t_readonly();
        logic [7:0] v;
        reg_write(7'h0C, 8'hFF);
        reg_read(7'h0C, v); check("R3 write C ignored", v, 8'h00);
        check("R3 irq after C write", {7'h0, irq}, 8'h00);
        reg_write(7'h0D, 8'h00);
        reg_read(7'h0D, v); check("R3 write D ignored", v, 8'h80);
    endtask

    task automatic t_flags();
        logic [7:0] v;
        pulse(0);
        check("R5 disabled flag no irq", {7'h0, irq}, 8'h00);
        reg_read(7'h0C, v); check("R5 periodic flag only", v, 8'h40);
        reg_read(7'h0C, v); check("R4 C cleared", v, 8'h00);
        reg_write(7'h0B, 8'h42);
        pulse(0);
        check("R5 enabled flag irq", {7'h0, irq}, 8'h01);
        reg_read(7'h0C, v); check("R5 IRQF with periodic", v, 8'hC0);
        check("R4 irq dropped by read", {7'h0, irq}, 8'h00);
        reg_read(7'h0C, v); check("R4 C empty after read", v, 8'h00);
        check("R10 irq matches IRQF", {7'h0, irq}, {7'h0, v[7]});
    endtask

    task automatic t_bwrite();
        logic [7:0] v;
        reg_write(7'h0B, 8'h02);
        pulse(1);
        check("R6 alarm pending no irq", {7'h0, irq}, 8'h00);
        reg_write(7'h0B, 8'h22);
        check("R6 enable on set flag raises", {7'h0, irq}, 8'h01);
        reg_write(7'h0B, 8'h02);
        check("R6 disable lowers", {7'h0, irq}, 8'h00);
        reg_read(7'h0C, v); check("R6 flag kept IRQF clear", v, 8'h20);
        check("R6 reg B output", ctrl_b, 8'h02);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        reg_write(7'h0B, 8'h12);
        bus_write(1'b0, 8'h0C);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 1'b1; uf_set = 1'b1;
        #2 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; uf_set = 1'b0;
        check("R9 colliding read excludes flag", v, 8'h00);
        check("R9 irq kept", {7'h0, irq}, 8'h01);
        bus_read(1'b1, v); check("R9 flag returned next read", v, 8'h90);
        reg_write(7'h0B, 8'h02);
    endtask

    task automatic t_uip();
        logic [7:0] v;
        @(negedge clk); uip_in = 1'b1;
        reg_read(7'h0A, v); check("R7 uip reflected", v, 8'hA6);
        reg_write(7'h0A, 8'h2F);
        reg_read(7'h0A, v); check("R7 write keeps uip", v, 8'hAF);
        @(negedge clk); uip_in = 1'b0;
        reg_write(7'h0A, 8'hFF);
        reg_read(7'h0A, v); check("R7 write cannot set uip", v, 8'h7F);
        check("R7 ctrl_a output", ctrl_a, 8'h7F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_values();
        t_index_and_store();
        t_readonly();
        t_flags();
        t_bwrite();
        t_collision();
        t_uip();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule